// File: doc/BRIEF.md
# Associative Page Translation Lookup

This block turns a 14-bit virtual word address into a 13-bit physical address using a small content-addressed page table. The upper three address bits name one of eight virtual pages, and the lower eleven bits are the word offset inside a 2K-word page. The table has four entries. Each entry holds a valid flag, a virtual page tag and a 2-bit physical block number. Every lookup compares all valid entries against the page field at the same time. The offset is passed through unchanged.

There are fewer entries than virtual pages, so any page that has no valid entry raises a page fault. Software fills or invalidates entries through a plain write port.

Lookup requests enter on a valid/ready stream. Results leave on a second valid/ready stream, one clock after the request is accepted. The block holds one result at a time. A request is accepted only when the result slot is empty or is being drained in that same cycle. While the consumer holds `rsp_ready` low, the result stays frozen and `req_ready` stays low, so no request is lost or overwritten.

Top module: `assoc_page_map`

## Requirements
- R1: After reset every table entry is invalid. `rsp_valid` is 0, `req_ready` is 1, and every lookup reports a fault until entries are loaded.
- R2: When a valid entry's tag equals address bits [13:11], the result has `rsp_hit`=1 and `rsp_fault`=0. `rsp_paddr` equals the entry's block number in bits [12:11] and address bits [10:0] in bits [10:0].
- R3: When no valid entry matches, the result has `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R4: Whenever `rsp_valid` is 1, exactly one of `rsp_hit` and `rsp_fault` is 1.
- R5: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) makes `rsp_valid` 1 after that edge. If a result is consumed and no request is accepted at the same edge, `rsp_valid` returns to 0.
- R6: While `rsp_valid` is 1 and `rsp_ready` is 0, the result outputs hold their values and no new request is accepted.
- R7: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1.
- R8: If several valid entries carry the same tag, the entry with the lowest index supplies the block number.
- R9: A write with `wr_en`=1 stores `wr_vld`, `wr_vpn` and `wr_pbn` into entry `wr_idx` at the clock edge. Writing `wr_vld`=0 invalidates the entry. A lookup accepted at the same edge as the write still sees the old contents.
- R10: With entries {page 0→block 3, page 2→block 1, page 5→block 2, page 6→block 0} loaded, every address in pages 1, 3, 4 and 7 faults, and the four mapped pages hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 2 | Entry index to write |
| wr_vld | input | 1 | Valid flag to store |
| wr_vpn | input | 3 | Virtual page tag to store |
| wr_pbn | input | 2 | Physical block number to store |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_vaddr | input | 14 | Virtual word address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_paddr | output | 13 | Physical address (0 on fault) |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page fault |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that `rsp_ready` is driven to a known level whenever `rsp_valid` is high. They place no demand on `req_valid` being held: a request that is not accepted may change or be withdrawn. The stimulus drives every input on the falling edge, so that each one is settled well before the rising edge. It keeps `rsp_ready` known at all times, and the stall sequence changes `req_vaddr` on purpose while `req_ready` is low.

// File: rtl/apm_pkg.sv
package apm_pkg;
  parameter int OFS_W   = 11;
  parameter int VPN_W   = 3;
  parameter int PBN_W   = 2;
  parameter int ENTRIES = 4;
  localparam int VA_W  = VPN_W + OFS_W;
  localparam int PA_W  = PBN_W + OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic             vld;
    logic [VPN_W-1:0] vpn;
    logic [PBN_W-1:0] pbn;
  } apm_entry_t;
endpackage

// File: rtl/apm_entry_store.sv
module apm_entry_store
  import apm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_vld,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic [PBN_W-1:0]            wr_pbn,
  output apm_entry_t [ENTRIES-1:0]    tbl_o
);
  apm_entry_t [ENTRIES-1:0] tbl_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        tbl_q[g].vld <= wr_vld;
        tbl_q[g].vpn <= wr_vpn;
        tbl_q[g].pbn <= wr_pbn;
      end
    end
  end

  assign tbl_o = tbl_q;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tbl_q[$past(wr_idx)].vld == $past(wr_vld))); // R9
endmodule

// File: rtl/apm_match.sv
module apm_match
  import apm_pkg::*;
(
  input  apm_entry_t [ENTRIES-1:0] tbl_i,
  input  logic [VPN_W-1:0]         vpn_i,
  output logic                     hit_o,
  output logic [PBN_W-1:0]         pbn_o
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = tbl_i[g].vld && (tbl_i[g].vpn == vpn_i);
  end

  // Scan from the top index down so the lowest matching index is written last.
  always_comb begin
    hit_o = 1'b0;
    pbn_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        pbn_o = tbl_i[i].pbn;
      end
    end
  end
endmodule

// File: rtl/apm_rsp_stage.sv
module apm_rsp_stage
  import apm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            hit_i,
  input  logic [PA_W-1:0] paddr_i,
  input  logic            rsp_ready_i,
  output logic            rsp_valid_o,
  output logic            rsp_hit_o,
  output logic            rsp_fault_o,
  output logic [PA_W-1:0] rsp_paddr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else if (load_i) begin
      rsp_valid_o <= 1'b1;
      rsp_hit_o   <= hit_i;
      rsp_fault_o <= !hit_i;
      rsp_paddr_o <= hit_i ? paddr_i : '0;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_hit_o) && $stable(rsp_fault_o))); // R6
endmodule

// File: rtl/assoc_page_map.sv
module assoc_page_map
  import apm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_vld,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PBN_W-1:0]  wr_pbn,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_hit,
  output logic              rsp_fault
);
  apm_entry_t [ENTRIES-1:0] tbl;
  logic                     lk_hit;
  logic [PBN_W-1:0]         lk_pbn;
  logic                     accept;

  apm_entry_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_vld (wr_vld),
    .wr_vpn (wr_vpn),
    .wr_pbn (wr_pbn),
    .tbl_o  (tbl)
  );

  apm_match u_match (
    .tbl_i (tbl),
    .vpn_i (req_vaddr[VA_W-1:OFS_W]),
    .hit_o (lk_hit),
    .pbn_o (lk_pbn)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  apm_rsp_stage u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .hit_i       (lk_hit),
    .paddr_i     ({lk_pbn, req_vaddr[OFS_W-1:0]}),
    .rsp_ready_i (rsp_ready),
    .rsp_valid_o (rsp_valid),
    .rsp_hit_o   (rsp_hit),
    .rsp_fault_o (rsp_fault),
    .rsp_paddr_o (rsp_paddr)
  );

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_fault)); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R5
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!rsp_hit || (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])))); // R2
endmodule

// File: tb/test_assoc_page_map.sv
module test_assoc_page_map;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_vld, req_valid, rsp_ready;
  logic [1:0]  wr_idx, wr_pbn;
  logic [2:0]  wr_vpn;
  logic [13:0] req_vaddr;
  logic        req_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [12:0] rsp_paddr;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  assoc_page_map i_assoc_page_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vld(wr_vld),
    .wr_vpn(wr_vpn), .wr_pbn(wr_pbn), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ent(input int idx, input bit v, input int vpn, input int pbn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_vld = v; wr_vpn = 3'(vpn); wr_pbn = 2'(pbn);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One lookup; checks the result one cycle after acceptance.
  task automatic lookup(input string req, input int page, input int ofs,
                        input bit exp_hit, input int blk);
    logic [12:0] exp_pa;
    exp_pa = exp_hit ? 13'((blk << 11) | ofs) : 13'd0;
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; req_vaddr = 14'((page << 11) | ofs);
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"},   32'(rsp_hit),   32'(exp_hit));
    check({req, " fault"}, 32'(rsp_fault), 32'(!exp_hit));
    check({req, " paddr"}, 32'(rsp_paddr), 32'(exp_pa));
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 req_ready after reset", 32'(req_ready), 32'd1);
    for (int p = 0; p < 8; p++) lookup("R1 empty table", p, 17 * p, 1'b0, 0);
  endtask

  task automatic t_load_example;
    write_ent(0, 1'b1, 0, 3);
    write_ent(1, 1'b1, 2, 1);
    write_ent(2, 1'b1, 5, 2);
    write_ent(3, 1'b1, 6, 0);
  endtask

  task automatic t_hits;
    lookup("R2 page0", 0, 0,     1'b1, 3);
    lookup("R2 page2", 2, 11'h7FF, 1'b1, 1);
    lookup("R2 page5", 5, 11'h2A5, 1'b1, 2);
    lookup("R2 page6", 6, 11'h400, 1'b1, 0);
  endtask

  task automatic t_faults;
    lookup("R10 R3 page1", 1, 0,      1'b0, 0);
    lookup("R10 R3 page3", 3, 11'h7FF, 1'b0, 0);
    lookup("R10 R3 page4", 4, 11'h123, 1'b0, 0);
    lookup("R10 R3 page7", 7, 11'h5A5, 1'b0, 0);
  endtask

  task automatic t_priority;
    write_ent(3, 1'b1, 0, 1);              // duplicate tag for page 0 in entry 3
    lookup("R8 lowest index wins", 0, 11'h033, 1'b1, 3);
    write_ent(0, 1'b0, 0, 3);              // invalidate entry 0
    lookup("R8 R9 next entry after invalidate", 0, 11'h033, 1'b1, 1);
    lookup("R9 overwritten page6 faults", 6, 5, 1'b0, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    rsp_ready = 1'b1;
    wr_en = 1'b1; wr_idx = 2'd1; wr_vld = 1'b1; wr_vpn = 3'd7; wr_pbn = 2'd2;
    req_valid = 1'b1; req_vaddr = 14'((7 << 11) | 9);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R9 same-cycle lookup sees old table", 32'(rsp_fault), 32'd1);
    lookup("R9 later lookup sees new entry", 7, 9, 1'b1, 2);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    check("R5 rsp_valid drops after drain", 32'(rsp_valid), 32'd0);
    rsp_ready = 1'b0; req_valid = 1'b1; req_vaddr = 14'((5 << 11) | 3);
    @(negedge clk);
    check("R5 result after one cycle", 32'(rsp_valid), 32'd1);
    check("R7 req_ready low when stalled", 32'(req_ready), 32'd0);
    req_vaddr = 14'((0 << 11) | 4);        // page 0 -> block 1 now
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 held valid", 32'(rsp_valid), 32'd1);
      check("R6 held paddr", 32'(rsp_paddr), 32'((2 << 11) | 3));
      check("R6 no accept while stalled", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    #0.5;
    check("R7 req_ready with rsp_ready", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 R5 second result", 32'(rsp_paddr), 32'((1 << 11) | 4));
    check("R5 second valid", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    check("R5 idle after drain", 32'(rsp_valid), 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_vld = 1'b0; wr_vpn = '0; wr_pbn = '0;
    req_valid = 1'b0; req_vaddr = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_example();
    t_hits();
    t_faults();
    t_priority();
    t_same_cycle();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule